// File: doc/BRIEF.md
# On-chip XDATA RAM access router

This block sits on the external-data port of an 8-bit microcontroller core. It sends each read or write either to a small on-chip XDATA RAM or to the external memory bus. A two-bit control register in the special-function space sets the routing. One bit is a global disable for the on-chip RAM. The other bit decides whether accesses that go to the on-chip RAM still pulse the external read and write strobes, so that bus activity stays visible.

The block decodes each request against a parameterised RAM window, which by default is the top 2 KB of the 64 KB data space (0xF800 to 0xFFFF). It writes the RAM, or returns data from it, and drives the registered external address, write data and strobes. Reads from either target come back with a fixed latency and a one-cycle valid flag.

Top module: `xdata_router`

## Requirements
- R1: After synchronous reset, the control bits hold 2'b01: the on-chip RAM is disabled and the visibility bit is clear. Once reset has been released for one clock, a register read at the control address returns 0xFD. ext_rd, ext_wr and core_rvalid are low.
- R2: When sfr_we is high and sfr_addr equals 0xB1, bits 1:0 of sfr_wdata load the control bits at that clock edge. Bit 0 is the RAM-disable bit and bit 1 is the visibility bit. sfr_rdata is registered. For address 0xB1 it returns the six upper bits as 1 and the control bits in bits 1:0. For any other address it returns 0x00. A write to any other address leaves the control bits unchanged.
- R3: While bit 0 is 1, every access goes to the external bus with its normal strobe, whatever the value of bit 1. Read data then comes from ext_rdata_in. A write inside the window does not change the on-chip RAM.
- R4: While bit 0 is 0, an access inside the window goes to the on-chip RAM. A write updates the RAM at the edge where the request is sampled. A read returns the stored byte.
- R5: An on-chip access with bit 1 at 0 leaves ext_rd and ext_wr low.
- R6: An on-chip access with bit 1 at 1 pulses ext_rd or ext_wr, with ext_addr and ext_wdata driven. Read data still comes from the on-chip RAM, and ext_rdata_in is ignored.
- R7: An access outside the window always uses the external bus with its strobe, for every combination of the control bits. Read data comes from ext_rdata_in.
- R8: A strobe is a single-cycle pulse that is registered at the edge where the request is sampled. ext_rd and ext_wr are never high together. Neither strobe is high in the cycle after a clock with no request. ext_rdata_in is sampled at the edge that follows the strobe cycle.
- R9: Every read produces exactly one single-cycle core_rvalid, two clock edges after its request is sampled. Writes produce none.
- R10: The window bounds are inclusive. 0xF800 and 0xFFFF are on-chip addresses. 0xF7FF is external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_we | input | 1 | Register write enable |
| sfr_rdata | output | 8 | Registered register read data |
| core_req | input | 1 | Data-space access request, one cycle per access |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 16 | Data-space address |
| core_wdata | input | 8 | Write data |
| core_rdata | output | 8 | Read data |
| core_rvalid | output | 1 | Read data valid pulse |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_rdata_in | input | 8 | External bus read data |

## Verification
The assertions assume that core_req is a single-cycle pulse per access and that core_we and core_addr are stable while it is high. They also assume that the register port is not written in the same cycle as a data access whose routing depends on it. The bench drives each access for exactly one cycle and changes the control bits only between accesses. It places distinct junk on ext_rdata_in during every strobe cycle, so that on-chip reads can show that external data is ignored. Back-to-back reads to both targets exercise the fixed two-edge latency.

// File: rtl/xram_router_pkg.sv
package xram_router_pkg;
  // bit positions inside the control register; the decoder depends on them
  localparam int CTRL_OFF = 0;  // 1 = on-chip RAM disabled
  localparam int CTRL_VIS = 1;  // 1 = strobes visible on on-chip access
  localparam int CTRL_W   = 2;

  typedef struct packed {
    logic to_ram;
    logic ext_strobe;
  } route_t;
endpackage

// File: rtl/xram_ctrl_reg.sv
module xram_ctrl_reg
  import xram_router_pkg::*;
#(
  parameter int SFR_AW = 8,
  parameter int DATA_W = 8,
  parameter logic [SFR_AW-1:0] SFR_ADDR = 8'hB1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int PAD_W = DATA_W - CTRL_W;

  logic hit;
  assign hit = (sfr_addr == SFR_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= 2'b01;
      sfr_rdata <= '0;
    end else begin
      if (sfr_we && hit) ctrl <= sfr_wdata[CTRL_W-1:0];
      sfr_rdata <= hit ? {{PAD_W{1'b1}}, ctrl} : '0;
    end
  end

  AST_CTRL_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ctrl == 2'b01);  // R1
  AST_FOREIGN_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sfr_we && !hit) |=> $stable(ctrl));  // R2
endmodule

// File: rtl/xram_decode.sv
module xram_decode
  import xram_router_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned XRAM_BASE  = 32'hF800,
  parameter int unsigned XRAM_DEPTH = 2048
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] ctrl,
  output route_t            route
);
  localparam int unsigned WIN_LAST = XRAM_BASE + XRAM_DEPTH - 1;

  logic in_win;

  always_comb begin
    in_win           = (32'(addr) >= XRAM_BASE) && (32'(addr) <= WIN_LAST);
    route.to_ram     = in_win && !ctrl[CTRL_OFF];
    route.ext_strobe = !route.to_ram || ctrl[CTRL_VIS];
  end
endmodule

// File: rtl/xram_array.sv
module xram_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2048,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     idx,
  input  logic              we,
  input  logic              re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/xdata_router.sv
module xdata_router
  import xram_router_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          SFR_AW     = 8,
  parameter logic [7:0]  SFR_ADDR   = 8'hB1,
  parameter int unsigned XRAM_BASE  = 32'hF800,
  parameter int unsigned XRAM_DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_rvalid,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              ext_rd,
  output logic              ext_wr,
  input  logic [DATA_W-1:0] ext_rdata_in
);
  localparam int AW = $clog2(XRAM_DEPTH);

  logic [CTRL_W-1:0] ctrl;
  route_t            route;
  logic [AW-1:0]     ram_idx;
  logic [DATA_W-1:0] ram_q;
  logic              ram_we, ram_re;
  logic              pend_ram_rd, pend_ext_rd;

  xram_ctrl_reg #(.SFR_AW(SFR_AW), .DATA_W(DATA_W), .SFR_ADDR(SFR_AW'(SFR_ADDR))) u_ctrl (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ctrl(ctrl)
  );

  xram_decode #(.ADDR_W(ADDR_W), .XRAM_BASE(XRAM_BASE), .XRAM_DEPTH(XRAM_DEPTH)) u_dec (
    .addr(core_addr), .ctrl(ctrl), .route(route)
  );

  assign ram_idx = AW'(core_addr - ADDR_W'(XRAM_BASE));
  assign ram_we  = core_req &&  core_we && route.to_ram;
  assign ram_re  = core_req && !core_we && route.to_ram;

  xram_array #(.DATA_W(DATA_W), .DEPTH(XRAM_DEPTH)) u_ram (
    .clk(clk), .idx(ram_idx), .we(ram_we), .re(ram_re),
    .wdata(core_wdata), .rdata(ram_q)
  );

  // stage 1: strobes and bus address, pending-read flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_rd      <= 1'b0;
      ext_wr      <= 1'b0;
      ext_addr    <= '0;
      ext_wdata   <= '0;
      pend_ram_rd <= 1'b0;
      pend_ext_rd <= 1'b0;
    end else begin
      ext_rd      <= core_req && route.ext_strobe && !core_we;
      ext_wr      <= core_req && route.ext_strobe &&  core_we;
      pend_ram_rd <= ram_re;
      pend_ext_rd <= core_req && !core_we && !route.to_ram;
      if (core_req && route.ext_strobe) begin
        ext_addr  <= core_addr;
        ext_wdata <= core_wdata;
      end
    end
  end

  // stage 2: read return, external data sampled after the strobe cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      core_rvalid <= 1'b0;
      core_rdata  <= '0;
    end else begin
      core_rvalid <= pend_ram_rd || pend_ext_rd;
      if (pend_ram_rd)      core_rdata <= ram_q;
      else if (pend_ext_rd) core_rdata <= ext_rdata_in;
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd && ext_wr));  // R8
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !core_req |=> (!ext_rd && !ext_wr));  // R8
  AST_DISABLED_GOES_EXT: assert property (@(posedge clk) disable iff (rst)
    (core_req && ctrl[CTRL_OFF]) |=> (ext_rd || ext_wr));  // R3
  AST_HIDDEN_ONCHIP: assert property (@(posedge clk) disable iff (rst)
    (core_req && route.to_ram && !ctrl[CTRL_VIS]) |=> (!ext_rd && !ext_wr));  // R5
  AST_VISIBLE_ONCHIP: assert property (@(posedge clk) disable iff (rst)
    (core_req && route.to_ram && ctrl[CTRL_VIS]) |=> (ext_rd || ext_wr));  // R6
  AST_OUTSIDE_EXT: assert property (@(posedge clk) disable iff (rst)
    (core_req && !route.to_ram) |=> (ext_rd || ext_wr));  // R7
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (core_req && !core_we) |-> ##2 core_rvalid);  // R9
  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (core_req && core_we) |-> ##2 !core_rvalid);  // R9
endmodule

// File: tb/xdata_router_tb.sv
module xdata_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_rdata;
  logic        core_req = 1'b0, core_we = 1'b0;
  logic [15:0] core_addr = 16'h0;
  logic [7:0]  core_wdata = 8'h0, core_rdata;
  logic        core_rvalid;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata, ext_rdata_in = 8'h00;
  logic        ext_rd, ext_wr;

  always #4 clk = ~clk;  // 125 MHz

  xdata_router u_dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .core_req(core_req),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_rvalid(core_rvalid), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_rdata_in(ext_rdata_in)
  );

  typedef struct {
    logic [7:0] data;
    string      tag;
  } exp_t;

  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;
  exp_t       sb[$];
  exp_t       got;
  logic [7:0] ram_model [int];
  logic [1:0] m_ctrl = 2'b01;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read return
  always @(negedge clk) begin
    if (!rst && core_rvalid) begin
      if (sb.size() == 0) check(1'b0, "R9", "unexpected rvalid", 16'(core_rdata), 16'h0);
      else begin
        got = sb.pop_front();
        check(core_rdata === got.data, got.tag, "read data", 16'(core_rdata), 16'(got.data));
      end
    end
  end

  // driver: one access, called at a falling edge
  task automatic access(input bit we, input logic [15:0] a, input logic [7:0] wd,
                        input logic [7:0] junk, input string tag);
    bit to_ram = !m_ctrl[0] && (a >= 16'hF800);
    bit strobe = !to_ram || m_ctrl[1];
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = wd;
    @(negedge clk);
    core_req = 1'b0;
    check(ext_rd === (strobe && !we), tag, "ext_rd", 16'(ext_rd), 16'(strobe && !we));
    check(ext_wr === (strobe && we), tag, "ext_wr", 16'(ext_wr), 16'(strobe && we));
    if (strobe) check(ext_addr === a, tag, "ext_addr", ext_addr, a);
    if (strobe && we) check(ext_wdata === wd, tag, "ext_wdata", 16'(ext_wdata), 16'(wd));
    ext_rdata_in = junk;  // sampled at the next edge (R8)
    if (we && to_ram) ram_model[int'(a)] = wd;
    if (!we) begin
      exp_t e;
      e.data = to_ram ? ram_model[int'(a)] : junk;
      e.tag  = tag;
      sb.push_back(e);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
    if (a == 8'hB1) m_ctrl = d[1:0];
  endtask

  task automatic sfr_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    sfr_addr = a;
    @(negedge clk);
    check(sfr_rdata === exp, tag, "sfr_rdata", 16'(sfr_rdata), 16'(exp));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    sfr_addr = 8'hB1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(sfr_rdata === 8'hFD, "R1", "sfr reset readback", 16'(sfr_rdata), 16'hFD);
    check(!ext_rd && !ext_wr, "R1", "strobes idle", 16'({ext_rd, ext_wr}), 16'h0);
    check(!core_rvalid, "R1", "rvalid idle", 16'(core_rvalid), 16'h0);

    // mode 01: RAM disabled
    access(1'b1, 16'hF900, 8'h11, 8'h00, "R3");
    access(1'b0, 16'hF900, 8'h00, 8'h3C, "R3");
    access(1'b0, 16'h1234, 8'h00, 8'h5A, "R7");
    idle(3);

    // R2: register port
    sfr_write(8'hB1, 8'h00);
    sfr_check(8'hB1, 8'hFC, "R2");
    sfr_write(8'hB2, 8'h03);
    sfr_check(8'hB1, 8'hFC, "R2");
    sfr_check(8'hB2, 8'h00, "R2");

    // mode 00: on-chip, hidden
    access(1'b1, 16'hF900, 8'hA5, 8'h00, "R5");
    access(1'b1, 16'hF800, 8'h11, 8'h00, "R10");
    access(1'b1, 16'hFFFF, 8'h22, 8'h00, "R10");
    access(1'b1, 16'hF7FF, 8'h33, 8'h00, "R10");
    access(1'b0, 16'hF900, 8'h00, 8'hEE, "R4");
    access(1'b0, 16'hF800, 8'h00, 8'hEE, "R10");
    access(1'b0, 16'hFFFF, 8'h00, 8'hEE, "R10");
    access(1'b0, 16'hF7FF, 8'h00, 8'h77, "R10");
    access(1'b0, 16'h0042, 8'h00, 8'h19, "R7");
    idle(3);

    // mode 11: disabled, visibility bit has no effect
    sfr_write(8'hB1, 8'h03);
    access(1'b1, 16'hF900, 8'h99, 8'h00, "R3");
    access(1'b0, 16'hFFFF, 8'h00, 8'h44, "R3");
    idle(3);

    // mode 10: on-chip, visible strobes
    sfr_write(8'hB1, 8'h02);
    sfr_check(8'hB1, 8'hFE, "R2");
    access(1'b0, 16'hF900, 8'h00, 8'h5B, "R6");
    access(1'b1, 16'hF800, 8'h66, 8'h00, "R6");
    access(1'b0, 16'hF800, 8'h00, 8'hC3, "R6");
    access(1'b0, 16'h0100, 8'h00, 8'h12, "R7");
    idle(4);

    check(sb.size() == 0, "R9", "reads left without rvalid", 16'(sb.size()), 16'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule